// File: doc/BRIEF.md
# Privileged Trap Entry Sequencer

This block takes a trap request from the core pipeline and decides which privilege level handles it, machine or supervisor. It then updates the registers that record the trap in a single clock edge. The pipeline presents the cause word, the PC of the trapping instruction and, for some traps, a faulting address. Alongside these it presents the current privilege, the two delegation masks (one for exceptions, one for interrupts), the supervisor vector and the live status enable bits. On the next edge the block holds the new privilege, the redirect PC, the cause, return PC and bad-address record of the chosen level, and a rewritten copy of the status fields for the CSR file to take back.

The top bit of the cause word marks an interrupt. The block uses that bit to pick which mask decides delegation, and clears it before the remaining value is used as a bit index. Traps taken in machine mode are never delegated. The enable bit saved into the "previous enable" field is the one that belongs to the privilege the core was running at.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, priv_o is machine (3), pc_o equals the RESET_PC parameter (default 0x1000), and every cause, return-PC, bad-address and status output is zero.
- R2: When bit XLEN-1 of trap_cause is 1, the interrupt mask (ideleg) decides delegation, indexed by the cause with that bit cleared. When bit XLEN-1 is 0, the exception mask (edeleg) decides it.
- R3: A trap is routed to supervisor only if all three hold: cur_priv is user (0) or supervisor (1), the stripped cause is below XLEN, and the selected mask bit at that index is 1. Every other trap goes to machine, including one taken at the reserved level 2.
- R4: On a supervisor trap, pc_o becomes stvec with bits 1:0 forced to zero, scause_o becomes the full cause, sepc_o becomes trap_epc and priv_o becomes 1. The machine cause and return-PC outputs are unchanged.
- R5: On a supervisor trap, st_spie_o takes st_ie_i[cur_priv] and st_spp_o takes bit 0 of cur_priv. Bit 1 of st_ie_o becomes 0, and all other status outputs take the values on the status inputs. The bits of st_ie are 0 for user, 1 for supervisor, 2 reserved and 3 for machine.
- R6: On a machine trap, pc_o becomes the MTVEC_ADDR parameter (default 0x100), mcause_o becomes the full cause, mepc_o becomes trap_epc and priv_o becomes 3. The supervisor cause and return-PC outputs are unchanged.
- R7: On a machine trap, st_mpie_o takes st_ie_i[cur_priv] and st_mpp_o takes cur_priv. Bit 3 of st_ie_o becomes 0, and all other status outputs take the values on the status inputs.
- R8: The bad-address output of the handling level is loaded from badaddr only when badaddr_valid is 1. Otherwise both bad-address outputs keep their values.
- R9: In a cycle with trap_valid low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Trap request this cycle |
| trap_cause | input | XLEN | Cause word; top bit marks an interrupt |
| trap_epc | input | XLEN | PC of the trapping instruction |
| badaddr_valid | input | 1 | badaddr carries a faulting address |
| badaddr | input | XLEN | Faulting address |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| edeleg | input | XLEN | Exception delegation mask |
| ideleg | input | XLEN | Interrupt delegation mask |
| stvec | input | XLEN | Supervisor trap vector |
| st_ie_i | input | 4 | Per-level interrupt enables |
| st_spie_i | input | 1 | Supervisor previous enable |
| st_mpie_i | input | 1 | Machine previous enable |
| st_spp_i | input | 1 | Supervisor previous privilege |
| st_mpp_i | input | 2 | Machine previous privilege |
| priv_o | output | 2 | Privilege after the trap |
| pc_o | output | XLEN | Redirect PC |
| scause_o | output | XLEN | Supervisor cause record |
| sepc_o | output | XLEN | Supervisor return PC |
| sbadaddr_o | output | XLEN | Supervisor bad address |
| mcause_o | output | XLEN | Machine cause record |
| mepc_o | output | XLEN | Machine return PC |
| mbadaddr_o | output | XLEN | Machine bad address |
| st_ie_o | output | 4 | Updated enables |
| st_spie_o | output | 1 | Updated supervisor previous enable |
| st_mpie_o | output | 1 | Updated machine previous enable |
| st_spp_o | output | 1 | Updated supervisor previous privilege |
| st_mpp_o | output | 2 | Updated machine previous privilege |

## Verification
Random traps mix interrupt and exception causes. Their stripped values fall below, near and far above XLEN, and they are raised at all four privilege encodings against random masks. This separates correct use of the two masks from a swapped selection, and correct range rejection from an unchecked bit index. Directed cases place complementary bits in the two masks for the same index, so mask selection by the top bit is seen in isolation. They also raise traps from machine mode with all-ones masks and use a stripped cause equal to XLEN. Interleaved idle cycles, and traps with and without a bad address, show which registers may hold and which must load.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam int unsigned NUM_LEVELS = 4;

  typedef struct packed {
    logic [NUM_LEVELS-1:0] ie;
    logic                  spie;
    logic                  mpie;
    logic                  spp;
    logic [1:0]            mpp;
  } stat_t;

  localparam int unsigned BANK_S = 0;
  localparam int unsigned BANK_M = 1;
  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] cause,
  input  logic [1:0]      priv,
  input  logic [XLEN-1:0] edeleg,
  input  logic [XLEN-1:0] ideleg,
  output logic            to_super
);

  localparam int unsigned IDXW = $clog2(XLEN);
  localparam logic [XLEN-1:0] XLEN_V = XLEN;

  logic            is_irq;
  logic [XLEN-1:0] stripped;
  logic [XLEN-1:0] mask_sel;
  logic            in_range;
  logic            low_priv;
  logic            mask_bit;

  always_comb begin
    is_irq   = cause[XLEN-1];
    stripped = cause;
    stripped[XLEN-1] = 1'b0;
    mask_sel = is_irq ? ideleg : edeleg;
    in_range = (stripped < XLEN_V);
    mask_bit = mask_sel[stripped[IDXW-1:0]];
    low_priv = (priv == PRIV_U) || (priv == PRIV_S);
    to_super = low_priv && in_range && mask_bit;
  end

endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
  import trap_pkg::*;
(
  input  stat_t      cur,
  input  logic [1:0] priv,
  input  logic       to_super,
  output stat_t      nxt
);

  logic cur_en;

  always_comb begin
    cur_en = cur.ie[priv];
    nxt    = cur;
    if (to_super) begin
      nxt.spie        = cur_en;
      nxt.spp         = priv[0];
      nxt.ie[PRIV_S]  = 1'b0;
    end else begin
      nxt.mpie        = cur_en;
      nxt.mpp         = priv;
      nxt.ie[PRIV_M]  = 1'b0;
    end
  end

endmodule

// File: rtl/trap_save_bank.sv
module trap_save_bank #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            bad_en,
  input  logic [XLEN-1:0] cause_in,
  input  logic [XLEN-1:0] epc_in,
  input  logic [XLEN-1:0] bad_in,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] bad_q
);

  logic [XLEN-1:0] cause_d, epc_d, bad_d;
  logic            rec_ce, bad_ce;

  always_comb begin
    rec_ce  = wr_en;
    bad_ce  = wr_en && bad_en;
    cause_d = rec_ce ? cause_in : cause_q;
    epc_d   = rec_ce ? epc_in   : epc_q;
    bad_d   = bad_ce ? bad_in   : bad_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      epc_q   <= '0;
      bad_q   <= '0;
    end else begin
      if (rec_ce) begin
        cause_q <= cause_d;
        epc_q   <= epc_d;
      end
      if (bad_ce) begin
        bad_q <= bad_d;
      end
    end
  end

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int unsigned     XLEN        = 64,
  parameter logic [XLEN-1:0] MTVEC_ADDR  = 'h100,
  parameter logic [XLEN-1:0] RESET_PC    = 'h1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_epc,
  input  logic            badaddr_valid,
  input  logic [XLEN-1:0] badaddr,
  input  logic [1:0]      cur_priv,
  input  logic [XLEN-1:0] edeleg,
  input  logic [XLEN-1:0] ideleg,
  input  logic [XLEN-1:0] stvec,
  input  logic [3:0]      st_ie_i,
  input  logic            st_spie_i,
  input  logic            st_mpie_i,
  input  logic            st_spp_i,
  input  logic [1:0]      st_mpp_i,
  output logic [1:0]      priv_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] scause_o,
  output logic [XLEN-1:0] sepc_o,
  output logic [XLEN-1:0] sbadaddr_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] mbadaddr_o,
  output logic [3:0]      st_ie_o,
  output logic            st_spie_o,
  output logic            st_mpie_o,
  output logic            st_spp_o,
  output logic [1:0]      st_mpp_o
);

  localparam logic [XLEN-1:0] VEC_ALIGN = {{(XLEN-2){1'b1}}, 2'b00};

  logic            to_super;
  stat_t           stat_cur, stat_upd, stat_d, stat_q;
  logic [1:0]      priv_d, priv_q;
  logic [XLEN-1:0] pc_d, pc_q;

  logic [NUM_BANKS-1:0][XLEN-1:0] bk_cause, bk_epc, bk_bad;

  trap_route #(.XLEN(XLEN)) u_route (
    .cause    (trap_cause),
    .priv     (cur_priv),
    .edeleg   (edeleg),
    .ideleg   (ideleg),
    .to_super (to_super)
  );

  always_comb begin
    stat_cur.ie   = st_ie_i;
    stat_cur.spie = st_spie_i;
    stat_cur.mpie = st_mpie_i;
    stat_cur.spp  = st_spp_i;
    stat_cur.mpp  = st_mpp_i;
  end

  trap_status_upd u_stat (
    .cur      (stat_cur),
    .priv     (cur_priv),
    .to_super (to_super),
    .nxt      (stat_upd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (b == BANK_S) ? to_super : !to_super;
    trap_save_bank #(.XLEN(XLEN)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (trap_valid && sel),
      .bad_en   (badaddr_valid),
      .cause_in (trap_cause),
      .epc_in   (trap_epc),
      .bad_in   (badaddr),
      .cause_q  (bk_cause[b]),
      .epc_q    (bk_epc[b]),
      .bad_q    (bk_bad[b])
    );
  end

  always_comb begin
    priv_d = priv_q;
    pc_d   = pc_q;
    stat_d = stat_q;
    if (trap_valid) begin
      stat_d = stat_upd;
      if (to_super) begin
        priv_d = PRIV_S;
        pc_d   = stvec & VEC_ALIGN;
      end else begin
        priv_d = PRIV_M;
        pc_d   = MTVEC_ADDR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q <= PRIV_M;
      pc_q   <= RESET_PC;
      stat_q <= '0;
    end else if (trap_valid) begin
      priv_q <= priv_d;
      pc_q   <= pc_d;
      stat_q <= stat_d;
    end
  end

  assign priv_o     = priv_q;
  assign pc_o       = pc_q;
  assign scause_o   = bk_cause[BANK_S];
  assign sepc_o     = bk_epc[BANK_S];
  assign sbadaddr_o = bk_bad[BANK_S];
  assign mcause_o   = bk_cause[BANK_M];
  assign mepc_o     = bk_epc[BANK_M];
  assign mbadaddr_o = bk_bad[BANK_M];
  assign st_ie_o    = stat_q.ie;
  assign st_spie_o  = stat_q.spie;
  assign st_mpie_o  = stat_q.mpie;
  assign st_spp_o   = stat_q.spp;
  assign st_mpp_o   = stat_q.mpp;

  a_r3_machine_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && cur_priv == PRIV_M) |=> (priv_o == PRIV_M));

  a_r4_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (priv_o != PRIV_S || pc_o[1:0] == 2'b00));

  a_r6_fixed_vec: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (priv_o != PRIV_M || pc_o == MTVEC_ADDR));

  a_r5_r7_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> ((priv_o == PRIV_S) ? !st_ie_o[1] : !st_ie_o[3]));

  a_r8_bad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !badaddr_valid) |=> ($stable(sbadaddr_o) && $stable(mbadaddr_o)));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> ($stable(pc_o) && $stable(priv_o) && $stable(scause_o) &&
                     $stable(mcause_o) && $stable(st_ie_o)));

endmodule

// File: tb/trap_entry_seq_tb.sv
`timescale 1ns/1ps
module trap_entry_seq_tb;

  localparam int XLEN = 64;
  localparam logic [63:0] MVEC = 64'h100;
  localparam logic [63:0] RVEC = 64'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        trap_valid = 0, badaddr_valid = 0;
  logic [63:0] trap_cause = 0, trap_epc = 0, badaddr = 0;
  logic [1:0]  cur_priv = 0;
  logic [63:0] edeleg = 0, ideleg = 0, stvec = 0;
  logic [3:0]  st_ie_i = 0;
  logic        st_spie_i = 0, st_mpie_i = 0, st_spp_i = 0;
  logic [1:0]  st_mpp_i = 0;

  logic [1:0]  priv_o;
  logic [63:0] pc_o, scause_o, sepc_o, sbadaddr_o, mcause_o, mepc_o, mbadaddr_o;
  logic [3:0]  st_ie_o;
  logic        st_spie_o, st_mpie_o, st_spp_o;
  logic [1:0]  st_mpp_o;

  trap_entry_seq u_dut (.*);

  int n_cmp = 0, n_bad = 0;

  logic [1:0]  e_priv;
  logic [63:0] e_pc, e_sc, e_se, e_sb, e_mc, e_me, e_mb;
  logic [3:0]  e_ie;
  logic        e_spie, e_mpie, e_spp;
  logic [1:0]  e_mpp;
  logic        last_s;

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic goes_super(input logic [63:0] c, input logic [1:0] p,
                                      input logic [63:0] em, input logic [63:0] im);
    logic [63:0] s;
    logic [63:0] m;
    s = c & 64'h7FFF_FFFF_FFFF_FFFF;
    m = c[63] ? im : em;
    if (p > 2'd1) return 1'b0;
    if (s >= 64) return 1'b0;
    return m[s[5:0]];
  endfunction

  task automatic model_step();
    logic s;
    logic en;
    if (!trap_valid) return;
    s = goes_super(trap_cause, cur_priv, edeleg, ideleg);
    last_s = s;
    en = st_ie_i[cur_priv];
    e_ie = st_ie_i; e_spie = st_spie_i; e_mpie = st_mpie_i; e_spp = st_spp_i; e_mpp = st_mpp_i;
    if (s) begin
      e_priv = 2'd1; e_pc = {stvec[63:2], 2'b00};
      e_sc = trap_cause; e_se = trap_epc;
      if (badaddr_valid) e_sb = badaddr;
      e_spie = en; e_spp = cur_priv[0]; e_ie[1] = 1'b0;
    end else begin
      e_priv = 2'd3; e_pc = MVEC;
      e_mc = trap_cause; e_me = trap_epc;
      if (badaddr_valid) e_mb = badaddr;
      e_mpie = en; e_mpp = cur_priv; e_ie[3] = 1'b0;
    end
  endtask

  task automatic compare_all(input logic was_trap);
    string rp, rs;
    if (!was_trap) begin rp = "R9"; rs = "R9"; end
    else if (last_s) begin rp = "R4"; rs = "R5"; end
    else begin rp = "R6"; rs = "R7"; end
    chk(rp, "priv", {62'd0, priv_o}, {62'd0, e_priv});
    chk(rp, "pc", pc_o, e_pc);
    chk(rp, "scause", scause_o, e_sc);
    chk(rp, "sepc", sepc_o, e_se);
    chk(rp, "mcause", mcause_o, e_mc);
    chk(rp, "mepc", mepc_o, e_me);
    chk(was_trap ? "R8" : "R9", "sbad", sbadaddr_o, e_sb);
    chk(was_trap ? "R8" : "R9", "mbad", mbadaddr_o, e_mb);
    chk(rs, "status", {55'd0, st_ie_o, st_spie_o, st_mpie_o, st_spp_o, st_mpp_o},
        {55'd0, e_ie, e_spie, e_mpie, e_spp, e_mpp});
  endtask

  task automatic drive_and_check();
    logic v;
    v = trap_valid;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all(v);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic rand_inputs();
    int k;
    trap_valid = ($urandom_range(0, 3) != 0);
    badaddr_valid = $urandom_range(0, 1) == 1;
    k = $urandom_range(0, 3);
    if (k < 2) trap_cause = {61'd0, 3'($urandom_range(0, 7))} + 64'($urandom_range(0, 8));
    else if (k == 2) trap_cause = 64'($urandom_range(0, 80));
    else trap_cause = r64();
    trap_cause[63] = $urandom_range(0, 1) == 1;
    trap_epc = r64(); badaddr = r64(); stvec = r64();
    cur_priv = 2'($urandom_range(0, 3));
    edeleg = r64(); ideleg = r64();
    st_ie_i = 4'($urandom_range(0, 15));
    st_spie_i = $urandom_range(0, 1) == 1; st_mpie_i = $urandom_range(0, 1) == 1;
    st_spp_i = $urandom_range(0, 1) == 1; st_mpp_i = 2'($urandom_range(0, 3));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    e_priv = 2'd3; e_pc = RVEC; e_sc = 0; e_se = 0; e_sb = 0; e_mc = 0; e_me = 0; e_mb = 0;
    e_ie = 0; e_spie = 0; e_mpie = 0; e_spp = 0; e_mpp = 0; last_s = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "priv", {62'd0, priv_o}, 64'd3);
    chk("R1", "pc", pc_o, RVEC);
    chk("R1", "mcause", mcause_o, 64'd0);
    chk("R1", "scause", scause_o, 64'd0);
    chk("R1", "status", {59'd0, st_ie_o, st_spie_o}, 64'd0);

    // R2: same index, complementary masks; interrupt uses ideleg
    trap_valid = 1; badaddr_valid = 0; cur_priv = 2'd0; st_ie_i = 4'b0001;
    edeleg = 64'h0; ideleg = 64'h20; trap_cause = 64'h8000_0000_0000_0005;
    stvec = 64'h4000_0007; trap_epc = 64'h1234;
    drive_and_check();
    chk("R2", "irq via ideleg -> S", {62'd0, priv_o}, 64'd1);
    // R2: exception with same index uses edeleg (bit clear) -> M
    trap_cause = 64'h5;
    drive_and_check();
    chk("R2", "exc via edeleg -> M", {62'd0, priv_o}, 64'd3);
    // R3: machine mode with all-ones masks stays M
    cur_priv = 2'd3; edeleg = '1; ideleg = '1; trap_cause = 64'h2;
    drive_and_check();
    chk("R3", "from M not delegated", {62'd0, priv_o}, 64'd3);
    // R3: stripped cause equal to XLEN goes to M
    cur_priv = 2'd1; trap_cause = 64'h8000_0000_0000_0040;
    drive_and_check();
    chk("R3", "cause==XLEN -> M", {62'd0, priv_o}, 64'd3);
    // R3: reserved level 2 goes to M
    cur_priv = 2'd2; trap_cause = 64'h1;
    drive_and_check();
    chk("R3", "reserved level -> M", {62'd0, priv_o}, 64'd3);
    // R8: bad address with valid, then without
    cur_priv = 2'd1; trap_cause = 64'h3; badaddr_valid = 1; badaddr = 64'hDEAD_BEEF;
    drive_and_check();
    badaddr_valid = 0; badaddr = 64'h1111;
    drive_and_check();
    chk("R8", "sbad kept", sbadaddr_o, 64'hDEAD_BEEF);
    // R9: idle cycles
    trap_valid = 0; trap_cause = 64'h7; cur_priv = 0;
    drive_and_check();

    for (int i = 0; i < 800; i++) begin
      rand_inputs();
      drive_and_check();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule